// File: doc/BRIEF.md
# Configurable Multi-Lane Pixel Serializer

This block turns one parallel pixel per frame period into serial bit streams on up to three data lanes. It also drives a forwarded clock lane. A pixel carries 8-bit red, green and blue values and three sync flags: data-enable, horizontal sync and vertical sync. Each pixel becomes a 30-bit frame made of the colour bits, the sync flags and three even-parity bits.

A static 2-bit lane-select input picks the lane count:

| Code | Lanes | Bits per lane per frame |
|------|-------|-------------------------|
| 00 | 1 | 30 |
| 01 | 2 | 15 |
| 10 | 3 | 10 |
| 11 | none | test/idle |

The block runs entirely on the bit-rate clock. It raises `pix_take_o` in the cycle whose rising edge captures the pixel inputs, the lane select and the lane-reverse input. The source must present the next pixel while that strobe is high. The forwarded clock lane rises on bit 0 of every frame.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every data lane and the clock lane are low and `pix_take_o` is high.
- R2: Frame bit i (i = 0..29) is defined as follows. Bits 0..7 are red MSB first, bits 8..15 are green MSB first and bits 16..23 are blue MSB first. Bit 24 is DE, bit 25 is HS and bit 26 is VS. Bits 27, 28 and 29 are the even-parity bits of red, green and blue. Each parity bit is 1 when its byte has an odd number of ones.
- R3: With lane select 00 a frame lasts 30 bit periods, and logical lane 0 carries frame bits 0..29 in order.
- R4: With lane select 01 a frame lasts 15 bit periods on logical lanes 0 and 1.
- R5: With lane select 10 a frame lasts 10 bit periods on logical lanes 0, 1 and 2.
- R6: With N lanes active, logical lane k in bit period p of a frame carries frame bit k + p*N.
- R7: Lanes not used by the current mode stay low.
- R8: The clock lane is high in bit periods 0 .. ceil(L/2)-1 of each L-period frame and low for the rest. This gives 15 of 30, 8 of 15 and 5 of 10.
- R9: When lane reverse is 1, physical lane j outputs logical lane 2-j. Physical lanes 0 and 2 swap and lane 1 is unchanged.
- R10: Lane select 11 holds every data lane and the clock lane low. `pix_take_o` then stays high every cycle.
- R11: `pix_take_o` is high only in the last bit period of a frame, or while idle. Lane select, lane reverse and the pixel inputs are sampled only at that edge. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_sel_i | input | 2 | Lane count select (00/01/10, 11 idle) |
| lane_rev_i | input | 1 | Reverse physical lane order |
| de_i | input | 1 | Data-enable flag |
| hs_i | input | 1 | Horizontal sync flag |
| vs_i | input | 1 | Vertical sync flag |
| red_i | input | 8 | Red value |
| green_i | input | 8 | Green value |
| blue_i | input | 8 | Blue value |
| pix_take_o | output | 1 | Inputs are captured at the next rising edge |
| lane_o | output | 3 | Serial data lanes (physical order) |
| clk_lane_o | output | 1 | Forwarded clock lane |

## Verification
The bench sweeps every lane mode with both lane orders and a spread of pixel values, and rebuilds each frame bit by bit from R2.

- A wrong round-robin stride, or an off-by-one frame length, would shift bits between lanes or merge adjacent frames.
- An odd-parity slip would flip bits 27..29.
- A symmetric clock would break the 8-of-15 high time in two-lane mode.
- During every frame the bench drives different mode, order and pixel values. A design that samples them outside the frame boundary would change lanes mid-frame.
- Runs in the test code would expose any lane or clock that is not held low.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    MODE_1L   = 2'b00,
    MODE_2L   = 2'b01,
    MODE_3L   = 2'b10,
    MODE_TEST = 2'b11
  } lane_mode_e;

  function automatic int unsigned lanes_of(lane_mode_e m);
    case (m)
      MODE_2L: return 2;
      MODE_3L: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned frame_len(lane_mode_e m, int unsigned fw);
    return fw / lanes_of(m);
  endfunction
endpackage

// File: rtl/sps_frame_builder.sv
module sps_frame_builder #(
  parameter int unsigned COLOR_W = 8,
  localparam int unsigned FRAME_W = 3 * COLOR_W + 6
) (
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               de_i,
  input  logic               hs_i,
  input  logic               vs_i,
  output logic [FRAME_W-1:0] frame_o
);
  // MSB of frame_o is frame bit 0
  always_comb begin
    frame_o = {red_i, green_i, blue_i, de_i, hs_i, vs_i,
               ^red_i, ^green_i, ^blue_i};
  end
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int unsigned FRAME_W = 30,
  localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         lane_sel_i,
  input  logic               rev_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               load_o,
  output logic               run_o,
  output lane_mode_e         mode_o,
  output logic               rev_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   pos_o
);
  lane_mode_e         mode_q;
  logic               run_q, rev_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   pos_q, last_pos;
  lane_mode_e         sel_mode;

  assign sel_mode = lane_mode_e'(lane_sel_i);
  assign last_pos = CNT_W'(frame_len(mode_q, FRAME_W) - 1);
  assign load_o   = !run_q || (pos_q == last_pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      mode_q  <= MODE_1L;
      rev_q   <= 1'b0;
      frame_q <= '0;
      pos_q   <= '0;
    end else if (load_o) begin
      mode_q  <= sel_mode;
      rev_q   <= rev_i;
      frame_q <= frame_i;
      pos_q   <= '0;
      run_q   <= (sel_mode != MODE_TEST);
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign mode_o  = mode_q;
  assign rev_o   = rev_q;
  assign frame_o = frame_q;
  assign pos_o   = pos_q;

  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> pos_q <= last_pos); // R6
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load_o) |=> ($stable(mode_q) && $stable(rev_q) && $stable(frame_q))); // R11
  AST_TEST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && sel_mode == MODE_TEST) |=> !run_q); // R10
endmodule

// File: rtl/sps_lane_mux.sv
module sps_lane_mux
  import sps_pkg::*;
#(
  parameter int unsigned FRAME_W = 30,
  parameter int unsigned LANES   = 3,
  localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
  input  logic               run_i,
  input  lane_mode_e         mode_i,
  input  logic               rev_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   pos_i,
  output logic [LANES-1:0]   lane_o,
  output logic               clk_lane_o
);
  int unsigned n_lanes, len;
  logic [LANES-1:0] lane_log;

  always_comb begin
    n_lanes = lanes_of(mode_i);
    len     = frame_len(mode_i, FRAME_W);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned KU = k;
    int unsigned idx;
    logic [FRAME_W-1:0] sh;
    always_comb begin
      idx = KU + 32'(pos_i) * n_lanes;
      sh  = frame_i << idx;
      lane_log[k] = run_i && (KU < n_lanes) && (idx < FRAME_W) && sh[FRAME_W-1];
    end
    assign lane_o[k] = rev_i ? lane_log[LANES-1-k] : lane_log[k];
  end

  // ceil(len/2) high periods: 15/30, 8/15, 5/10
  assign clk_lane_o = run_i && (32'(pos_i) < (len + 1) / 2);
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import sps_pkg::*;
#(
  parameter int unsigned COLOR_W = 8,
  localparam int unsigned LANES   = 3,
  localparam int unsigned FRAME_W = 3 * COLOR_W + 6,
  localparam int unsigned CNT_W   = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         lane_sel_i,
  input  logic               lane_rev_i,
  input  logic               de_i,
  input  logic               hs_i,
  input  logic               vs_i,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  output logic               pix_take_o,
  output logic [LANES-1:0]   lane_o,
  output logic               clk_lane_o
);
  logic [FRAME_W-1:0] frame_in, frame_q;
  logic               run, rev;
  lane_mode_e         mode;
  logic [CNT_W-1:0]   pos;

  sps_frame_builder #(.COLOR_W(COLOR_W)) u_build (
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i), .frame_o(frame_in)
  );

  sps_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_sel_i(lane_sel_i), .rev_i(lane_rev_i),
    .frame_i(frame_in), .load_o(pix_take_o), .run_o(run), .mode_o(mode),
    .rev_o(rev), .frame_o(frame_q), .pos_o(pos)
  );

  sps_lane_mux #(.FRAME_W(FRAME_W), .LANES(LANES)) u_mux (
    .run_i(run), .mode_i(mode), .rev_i(rev), .frame_i(frame_q), .pos_i(pos),
    .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (lane_o == '0 && !clk_lane_o)); // R10
  AST_ONE_LANE_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode == MODE_1L) |-> $countones(lane_o) <= 1); // R7
  AST_CLK_RISE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_lane_o) |-> pos == '0); // R8
endmodule

// File: tb/pixel_serializer_tb.sv
module pixel_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lane_sel_i = 2'b00;
  logic       lane_rev_i = 1'b0;
  logic       de_i = 0, hs_i = 0, vs_i = 0;
  logic [7:0] red_i = 0, green_i = 0, blue_i = 0;
  logic       pix_take_o, clk_lane_o;
  logic [2:0] lane_o;

  int  n_checks = 0, n_fail = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  pixel_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lane_sel_i(lane_sel_i), .lane_rev_i(lane_rev_i),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i), .red_i(red_i), .green_i(green_i),
    .blue_i(blue_i), .pix_take_o(pix_take_o), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit par(logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return bit'(c % 2);
  endfunction

  // index i = frame bit i (R2)
  function automatic logic [29:0] exp_frame(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                                            bit de, bit hs, bit vs);
    logic [29:0] f;
    for (int i = 0; i < 8; i++) begin
      f[i] = r[7-i]; f[8+i] = g[7-i]; f[16+i] = b[7-i];
    end
    f[24] = de; f[25] = hs; f[26] = vs;
    f[27] = par(r); f[28] = par(g); f[29] = par(b);
    return f;
  endfunction

  // called at a negedge where pix_take_o should be high
  task automatic run_frame(int sel, bit rev, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                           bit de, bit hs, bit vs);
    int n = sel + 1;
    int len = 30 / n;
    int hi = (len + 1) / 2;
    logic [29:0] f = exp_frame(r, g, b, de, hs, vs);
    string tag = (sel == 0) ? "R3" : (sel == 1) ? "R4" : "R5";
    if (rev) tag = {tag, " R9"};
    lane_sel_i = 2'(sel); lane_rev_i = rev;
    red_i = r; green_i = g; blue_i = b; de_i = de; hs_i = hs; vs_i = vs;
    check("R11 take at boundary", int'(pix_take_o), 1);
    @(posedge clk);
    #1;
    // disturb all sampled inputs mid-frame (R11)
    lane_sel_i = 2'(sel ^ 1); lane_rev_i = ~rev;
    red_i = ~r; green_i = ~g; blue_i = ~b; de_i = ~de; hs_i = ~hs; vs_i = ~vs;
    for (int p = 0; p < len; p++) begin
      logic [2:0] exp_l = '0, mask = '0;
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
        int ph = rev ? 2 - k : k;
        exp_l[ph] = f[k + p * n];  // R6 round robin, R2 content
        mask[ph] = 1'b1;
      end
      check({tag, " R6 data lanes"}, int'(lane_o & mask), int'(exp_l));
      check("R7 unused lanes", int'(lane_o & ~mask), 0);
      check("R8 clock lane", int'(clk_lane_o), int'(p < hi));
      check("R11 take strobe", int'(pix_take_o), int'(p == len - 1));
    end
  endtask

  task automatic run_idle(int cycles);
    lane_sel_i = 2'b11;
    check("R10 take idle", int'(pix_take_o), 1);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check("R10 lanes idle", int'(lane_o), 0);
      check("R10 clock idle", int'(clk_lane_o), 0);
      check("R10 take idle", int'(pix_take_o), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 lanes in reset", int'(lane_o), 0);
    check("R1 clock in reset", int'(clk_lane_o), 0);
    rst_n = 1'b1;
    check("R1 lanes after reset", int'(lane_o), 0);
    check("R1 take after reset", int'(pix_take_o), 1);
    for (int sel = 0; sel < 3; sel++) begin
      for (int rv = 0; rv < 2; rv++) begin
        for (int t = 0; t < 6; t++) begin
          run_frame(sel, bit'(rv), 8'(t * 37 + 5), 8'(t * 91 + 17), 8'(t * 13 + 200),
                    bit'(t & 1), bit'((t >> 1) & 1), bit'((t >> 2) & 1));
        end
      end
      run_frame(sel, 1'b0, 8'hFF, 8'h00, 8'h81, 1'b1, 1'b1, 1'b1);
      run_idle(4);
    end
    // back-to-back mode switches at frame boundaries
    run_frame(2, 1'b1, 8'h5A, 8'hC3, 8'h01, 1'b1, 1'b0, 1'b1);
    run_frame(0, 1'b1, 8'h7E, 8'h10, 8'hF0, 1'b0, 1'b1, 1'b0);
    run_frame(1, 1'b1, 8'h33, 8'hEE, 8'h08, 1'b1, 1'b1, 1'b0);
    run_idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule